// File: doc/BRIEF.md
# Update-Protocol Snooping Cache Controller

This block keeps one processor's small direct-mapped cache coherent on a shared snooping bus. The bus uses update rather than invalidate: when a cache writes a line that others also hold, it broadcasts the new word, and every holder, as well as main memory, takes the new value. Each line is tracked as absent, clean-shared or dirty-exclusive. A wired-OR shared signal, sampled when this cache's own bus transaction completes, decides whether a line is kept clean-shared with write-through or dirty-exclusive with write-back.

Processor reads and writes enter through a request port and wait for a one-cycle done pulse. Misses and writes to shared lines go out on a bus master port as a bus read or a bus update, and a simple memory responder completes them with an acknowledge. A separate snoop port presents the transactions of other processors. The controller answers those in the same cycle by pulling the shared line, by supplying its dirty copy, or by taking the broadcast word into its own copy.

Top module: `snoop_update_cache`

## Requirements
- R1: After reset every line is absent, and cpuDone, busReq, snpPull and snpProvide are all 0. A snoop to any address after reset gets no response.
- R2: A read miss issues one bus read (busOp = 0) at the request address. On busAck it returns busRdata and installs the line: clean-shared if busShared was 1 at the acknowledge, dirty-exclusive if it was 0.
- R3: A read that hits returns the cached word and issues no bus transaction.
- R4: A write to a dirty-exclusive line updates only the local copy, with no bus transaction. A later read returns the new word.
- R5: A write to a clean-shared line issues one bus update (busOp = 1) that carries the write word. The line stays clean-shared if busShared was 1 at the acknowledge and becomes dirty-exclusive if it was 0, so later writes stay local.
- R6: A write miss first issues a bus read to allocate the line. It then completes as a write to the installed line: a bus update if the line was installed clean-shared, a local write if it was installed dirty-exclusive.
- R7: A snooped bus read (snpOp = 0) to a dirty-exclusive line raises snpPull and snpProvide with the line's word on snpProvideData, and the line becomes clean-shared.
- R8: A snooped bus read to a clean-shared line raises snpPull without snpProvide, and the line stays clean-shared.
- R9: A snooped bus update (snpOp = 1) to a clean-shared line raises snpPull, and the local copy takes snpData.
- R10: A snooped transaction to a line that is absent (invalid entry, or a different tag in the set) drives neither snpPull nor snpProvide and changes nothing.
- R11: A snooped bus update to a line held dirty-exclusive cannot occur in a coherent system and is flagged as an error.
- R12: The cache is direct mapped on the low address bits. A miss to an occupied set replaces the old line, and the old line is then absent for snoops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuWdata | input | DATA_W | Write word |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read word, valid with cpuDone |
| busReq | output | 1 | Bus transaction pending, held until busAck |
| busOp | output | 1 | 0 = bus read, 1 = bus update |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Broadcast word for a bus update |
| busAck | input | 1 | Transaction complete |
| busRdata | input | DATA_W | Line word returned by a bus read |
| busShared | input | 1 | Wired-OR shared line from the other caches |
| snpValid | input | 1 | Another processor's transaction is on the bus |
| snpOp | input | 1 | 0 = bus read, 1 = bus update |
| snpAddr | input | ADDR_W | Snooped address |
| snpData | input | DATA_W | Snooped update word |
| snpPull | output | 1 | Drive the shared line to 1 |
| snpProvide | output | 1 | This cache supplies the snooped line |
| snpProvideData | output | DATA_W | Supplied line word |

## Verification
The assertions take for granted a coherent system around the block. No other cache broadcasts an update to a line this cache holds dirty-exclusive, and no snoop arrives while this cache holds the bus, since arbitration serialises the two. The responder also keeps busRdata and busShared steady for the acknowledge cycle. The stimulus follows this. Snoops are issued only between processor requests, and snooped updates target only lines that are absent or clean-shared. Every line is evicted only while it is clean, so no dirty word is lost and the expected values stay well defined.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

  typedef enum logic [1:0] {
    LINE_NIC = 2'd0,
    LINE_CS  = 2'd1,
    LINE_DE  = 2'd2
  } lineState_t;

  localparam logic OP_BR = 1'b0;
  localparam logic OP_BU = 1'b1;

  typedef struct packed {
    logic       capture;    // latch the processor request
    logic       fill;       // install tag and bus word in the request set
    logic       writeWord;  // store the request write word
    logic       setState;   // load cpuState into the request set
    lineState_t cpuState;
    logic       snpWrite;   // store the snooped word in the snoop set
    logic       snpToCs;    // demote the snoop set to clean-shared
  } ctlStrobes_t;

endpackage

// File: rtl/suc_datapath.sv
module suc_datapath
  import upd_coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output lineState_t        cpuLineState,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_t        snpLineState,
  output logic [DATA_W-1:0] snpLineData
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWriteQ;
  logic [DATA_W-1:0] reqData;

  lineState_t        stateArr [SETS];
  logic [TAG_W-1:0]  tagArr   [SETS];
  logic [DATA_W-1:0] dataArr  [SETS];

  logic [IDX_W-1:0]  reqIdx, snpIdx;
  logic [TAG_W-1:0]  reqTag, snpTag;
  logic [SETS-1:0]   reqMatch, snpMatch;

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // per-set valid-and-tag compare for both lookup ports
  for (genvar g = 0; g < SETS; g++) begin : gMatch
    assign reqMatch[g] = (stateArr[g] != LINE_NIC) && (tagArr[g] == reqTag);
    assign snpMatch[g] = (stateArr[g] != LINE_NIC) && (tagArr[g] == snpTag);
  end

  assign cpuLineState = reqMatch[reqIdx] ? stateArr[reqIdx] : LINE_NIC;
  assign cpuLineData  = dataArr[reqIdx];
  assign snpLineState = snpMatch[snpIdx] ? stateArr[snpIdx] : LINE_NIC;
  assign snpLineData  = dataArr[snpIdx];

  assign reqWrite = reqWriteQ;
  assign busAddr  = reqAddr;
  assign busWdata = reqData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqWriteQ <= 1'b0;
      reqData   <= '0;
      for (int i = 0; i < SETS; i++) begin
        stateArr[i] <= LINE_NIC;
        tagArr[i]   <= '0;
        dataArr[i]  <= '0;
      end
    end else begin
      if (stb.capture) begin
        reqAddr   <= cpuAddr;
        reqWriteQ <= cpuWrite;
        reqData   <= cpuWdata;
      end
      if (stb.fill) begin
        tagArr[reqIdx]  <= reqTag;
        dataArr[reqIdx] <= busRdata;
      end
      if (stb.writeWord) dataArr[reqIdx] <= reqData;
      if (stb.setState)  stateArr[reqIdx] <= stb.cpuState;
      if (stb.snpWrite)  dataArr[snpIdx] <= snpData;
      if (stb.snpToCs)   stateArr[snpIdx] <= LINE_CS;
    end
  end

  // a filled line must be found by the next lookup of the same request
  assert_fill_hits_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.fill |=> cpuLineState != LINE_NIC);

endmodule

// File: rtl/suc_control.sv
module suc_control
  import upd_coh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        reqWrite,
  input  lineState_t  cpuLineState,
  input  logic        busAck,
  input  logic        busShared,
  input  logic        snpValid,
  input  logic        snpOp,
  input  lineState_t  snpLineState,
  output ctlStrobes_t stb,
  output logic        cpuDone,
  output logic        busReq,
  output logic        busOp,
  output logic        snpPull,
  output logic        snpProvide
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_BUS} ctlState_t;

  ctlState_t state, nextState;
  logic      opReg, opNext;

  assign busOp = opReg;

  always_comb begin
    stb       = '0;
    nextState = state;
    opNext    = opReg;
    cpuDone   = 1'b0;
    busReq    = 1'b0;
    snpPull   = 1'b0;
    snpProvide = 1'b0;

    // processor side
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          stb.capture = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!snpValid) begin
          unique case (cpuLineState)
            LINE_NIC: begin
              opNext    = OP_BR;
              nextState = ST_BUS;
            end
            LINE_CS: begin
              if (reqWrite) begin
                opNext    = OP_BU;
                nextState = ST_BUS;
              end else begin
                cpuDone   = 1'b1;
                nextState = ST_IDLE;
              end
            end
            default: begin
              stb.writeWord = reqWrite;
              cpuDone       = 1'b1;
              nextState     = ST_IDLE;
            end
          endcase
        end
      end
      default: begin
        busReq = 1'b1;
        if (busAck) begin
          stb.setState = 1'b1;
          stb.cpuState = busShared ? LINE_CS : LINE_DE;
          if (opReg == OP_BR) begin
            stb.fill  = 1'b1;
            nextState = ST_CHECK;
          end else begin
            stb.writeWord = 1'b1;
            cpuDone       = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
    endcase

    // snoop side
    if (snpValid) begin
      unique case (snpLineState)
        LINE_CS: begin
          snpPull      = 1'b1;
          stb.snpWrite = (snpOp == OP_BU);
        end
        LINE_DE: begin
          if (snpOp == OP_BR) begin
            snpPull     = 1'b1;
            snpProvide  = 1'b1;
            stb.snpToCs = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_BR;
    end else begin
      state <= nextState;
      opReg <= opNext;
    end
  end

  // a pending transaction holds its request and kind until acknowledged
  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busOp)));

  // a dirty-exclusive hit never reaches the bus
  assert_de_local_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !snpValid && cpuLineState == LINE_DE) |=> !busReq);

  // completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  // another cache broadcasting to our dirty line is incoherent
  assert_no_bu_on_de_R11: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpOp == OP_BU) |-> (snpLineState != LINE_DE));

endmodule

// File: rtl/snoop_update_cache.sv
module snoop_update_cache
  import upd_coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic              busOp,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic              snpOp,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output logic              snpPull,
  output logic              snpProvide,
  output logic [DATA_W-1:0] snpProvideData
);

  ctlStrobes_t stb;
  logic        reqWrite;
  lineState_t  cpuLineState, snpLineState;
  logic [DATA_W-1:0] cpuLineData, snpLineData;

  suc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cpuAddr      (cpuAddr),
    .cpuWrite     (cpuWrite),
    .cpuWdata     (cpuWdata),
    .busRdata     (busRdata),
    .snpAddr      (snpAddr),
    .snpData      (snpData),
    .reqWrite     (reqWrite),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .cpuLineState (cpuLineState),
    .cpuLineData  (cpuLineData),
    .snpLineState (snpLineState),
    .snpLineData  (snpLineData)
  );

  suc_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .reqWrite     (reqWrite),
    .cpuLineState (cpuLineState),
    .busAck       (busAck),
    .busShared    (busShared),
    .snpValid     (snpValid),
    .snpOp        (snpOp),
    .snpLineState (snpLineState),
    .stb          (stb),
    .cpuDone      (cpuDone),
    .busReq       (busReq),
    .busOp        (busOp),
    .snpPull      (snpPull),
    .snpProvide   (snpProvide)
  );

  assign cpuRdata       = cpuLineData;
  assign snpProvideData = snpLineData;

endmodule

// File: tb/test_snoop_update_cache.sv
module test_snoop_update_cache;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_SBR = 2'd2, K_SBU = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [31:0] data;
    logic        shr;
    logic [31:0] expData;
    logic [1:0]  expBr;
    logic [1:0]  expBu;
    logic        expPull;
    logic        expProv;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{K_RD,  16'h0011, 32'h0,        1'b0, 32'hBEEF0011, 2'd1, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 miss, DE
    '{K_RD,  16'h0011, 32'h0,        1'b0, 32'hBEEF0011, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 hit
    '{K_WR,  16'h0011, 32'h11111111, 1'b0, 32'h0,        2'd0, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 local
    '{K_RD,  16'h0011, 32'h0,        1'b0, 32'h11111111, 2'd0, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 readback
    '{K_SBR, 16'h0011, 32'h0,        1'b0, 32'h11111111, 2'd0, 2'd0, 1'b1, 1'b1, 4'd7},  // R7 provide
    '{K_WR,  16'h0011, 32'h22222222, 1'b1, 32'h0,        2'd0, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 stays CS
    '{K_WR,  16'h0011, 32'h33333333, 1'b0, 32'h0,        2'd0, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 to DE
    '{K_WR,  16'h0011, 32'h44444444, 1'b0, 32'h0,        2'd0, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 now local
    '{K_SBR, 16'h0011, 32'h0,        1'b0, 32'h44444444, 2'd0, 2'd0, 1'b1, 1'b1, 4'd7},  // R7
    '{K_RD,  16'h0022, 32'h0,        1'b1, 32'hBEEF0022, 2'd1, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 miss, CS
    '{K_SBU, 16'h0022, 32'h55555555, 1'b0, 32'h0,        2'd0, 2'd0, 1'b1, 1'b0, 4'd9},  // R9
    '{K_RD,  16'h0022, 32'h0,        1'b0, 32'h55555555, 2'd0, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 copy
    '{K_SBR, 16'h0022, 32'h0,        1'b0, 32'h0,        2'd0, 2'd0, 1'b1, 1'b0, 4'd8},  // R8
    '{K_SBR, 16'h0033, 32'h0,        1'b0, 32'h0,        2'd0, 2'd0, 1'b0, 1'b0, 4'd10}, // R10
    '{K_SBU, 16'h0044, 32'h66660000, 1'b0, 32'h0,        2'd0, 2'd0, 1'b0, 1'b0, 4'd10}, // R10
    '{K_WR,  16'h002B, 32'h66666666, 1'b1, 32'h0,        2'd1, 2'd1, 1'b0, 1'b0, 4'd6},  // R6 BR+BU
    '{K_SBR, 16'h002B, 32'h0,        1'b0, 32'h0,        2'd0, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 CS
    '{K_WR,  16'h003C, 32'h77777777, 1'b0, 32'h0,        2'd1, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 BR only
    '{K_SBR, 16'h003C, 32'h0,        1'b0, 32'h77777777, 2'd0, 2'd0, 1'b1, 1'b1, 4'd6},  // R6 DE
    '{K_RD,  16'h0019, 32'h0,        1'b1, 32'hBEEF0019, 2'd1, 2'd0, 1'b0, 1'b0, 4'd12}, // R12 evict
    '{K_SBR, 16'h0011, 32'h0,        1'b0, 32'h0,        2'd0, 2'd0, 1'b0, 1'b0, 4'd12}  // R12 gone
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuDone;
  logic [DATA_W-1:0] cpuRdata;
  logic busReq, busOp;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic busAck = 1'b0;
  logic [DATA_W-1:0] busRdata = '0;
  logic busShared = 1'b0;
  logic snpValid = 1'b0, snpOp = 1'b0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [DATA_W-1:0] snpData = '0;
  logic snpPull, snpProvide;
  logic [DATA_W-1:0] snpProvideData;

  int checks = 0, fails = 0;
  int brCnt = 0, buCnt = 0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_update_cache i_snoop_update_cache (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busOp(busOp), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busShared(busShared),
    .snpValid(snpValid), .snpOp(snpOp), .snpAddr(snpAddr), .snpData(snpData),
    .snpPull(snpPull), .snpProvide(snpProvide), .snpProvideData(snpProvideData)
  );

  // memory responder: acknowledges a pending transaction one half cycle later
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 1'b0;
    end else if (busReq && !busAck) begin
      busAck   = 1'b1;
      busRdata = mem[busAddr[7:0]];
      if (busOp) begin
        mem[busAddr[7:0]] = busWdata;
        buCnt++;
      end else begin
        brCnt++;
      end
    end else begin
      busAck = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpuOp(input logic wr, input logic [15:0] a, input logic [31:0] d,
                       input logic shr, output logic [31:0] rd, output logic ok);
    ok = 1'b0;
    rd = '0;
    @(negedge clk);
    busShared = shr;
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk); #1;
      if (cpuDone) begin
        rd = cpuRdata;
        ok = 1'b1;
        break;
      end
    end
    cpuReq = 1'b0;
  endtask

  task automatic snoop(input logic op, input logic [15:0] a, input logic [31:0] d,
                       output logic pull, output logic prov, output logic [31:0] pd);
    @(negedge clk);
    snpValid = 1'b1; snpOp = op; snpAddr = a; snpData = d;
    #1;
    pull = snpPull; prov = snpProvide; pd = snpProvideData;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, pd;
    logic ok, pull, prov;
    int br0, bu0;
    string tag;

    for (int i = 0; i < 256; i++) mem[i] = {16'hBEEF, 8'h00, i[7:0]};

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 cpuDone", {31'd0, cpuDone}, 32'd0);
    chk("R1 busReq", {31'd0, busReq}, 32'd0);
    chk("R1 snpPull", {31'd0, snpPull}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      br0 = brCnt; bu0 = buCnt;
      if (VECS[v].kind == K_RD || VECS[v].kind == K_WR) begin
        cpuOp(VECS[v].kind == K_WR, VECS[v].addr, VECS[v].data, VECS[v].shr, rd, ok);
        chk({tag, " done"}, {31'd0, ok}, 32'd1);
        if (VECS[v].kind == K_RD) chk({tag, " data"}, rd, VECS[v].expData);
        chk({tag, " bus reads"}, brCnt - br0, {30'd0, VECS[v].expBr});
        chk({tag, " bus updates"}, buCnt - bu0, {30'd0, VECS[v].expBu});
        if (VECS[v].kind == K_WR && VECS[v].expBu != 0)
          chk({tag, " memory updated"}, mem[VECS[v].addr[7:0]], VECS[v].data);
      end else begin
        snoop(VECS[v].kind == K_SBU, VECS[v].addr, VECS[v].data, pull, prov, pd);
        chk({tag, " pull"}, {31'd0, pull}, {31'd0, VECS[v].expPull});
        chk({tag, " provide"}, {31'd0, prov}, {31'd0, VECS[v].expProv});
        if (VECS[v].expProv) chk({tag, " provided word"}, pd, VECS[v].expData);
      end
    end

    // R1 reset mid-run clears every line: the former dirty line 0x3C is absent
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 snpProvide in reset", {31'd0, snpProvide}, 32'd0);
    rstN = 1'b1;
    snoop(1'b0, 16'h003C, 32'h0, pull, prov, pd);
    chk("R1 no pull after reset", {31'd0, pull}, 32'd0);
    chk("R1 no provide after reset", {31'd0, prov}, 32'd0);
    br0 = brCnt;
    cpuOp(1'b0, 16'h0022, 32'h0, 1'b0, rd, ok);
    chk("R1 read after reset misses", brCnt - br0, 32'd1);
    chk("R2 data after reset", rd, mem[8'h22]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule